// File: doc/BRIEF.md
# I2C Target Byte Receiver with Software-Released Clock Stretch

This block is the receive side of an I2C target. It samples the bus lines with the system clock, finds start and stop conditions, and shifts in the 7-bit address and the direction bit that follows it. It compares the address with a programmable own address. On a match it acknowledges in hardware, with no software action. After that it takes in write data bytes, MSB first, and acknowledges each one when the acknowledge enable is set.

After the ninth clock of every byte it accepts, the block holds SCL low. It keeps the bus stalled until software pulses a release strobe. At the same moment it raises a one-cycle interrupt, with a flag that tells an address match apart from a finished data byte. If the address does not match, the block stays off the bus until the next start: it gives no acknowledge, raises no interrupt and does not stall SCL.

The bus pins are modelled as open-drain. The block reads the wired level of each line and drives an active-high pull-down enable for each one.

Top module: `i2cTgtStretch`

## Requirements
- R1: When the seven bits after a start equal `ownAddr`, `sdaLow` is 1 from the falling SCL edge after the eighth bit until the ninth falling SCL edge, so the controller sees ACK.
- R2: At the ninth falling SCL edge of a matched address byte, `sclLow` rises and `irq` pulses with `irqAddr` = 1.
- R3: On an address mismatch, `sdaLow`, `sclLow` and `irq` stay 0 until the next start, and `rxData` keeps its value through any bytes that follow.
- R4: Once set, `sclLow` stays 1 until a cycle in which `waitRelease` is 1, and it is 0 in the following cycle.
- R5: For a data byte after a matched address, with `ackEnable` = 1, `sdaLow` is 1 during the ninth clock.
- R6: At the ninth falling SCL edge of a data byte, `sclLow` rises and `irq` pulses with `irqAddr` = 0. `rxData` holds the byte, with the first bit received in bit 7.
- R7: With `ackEnable` = 0, a data byte is not acknowledged (`sdaLow` stays 0), yet it still stalls SCL and is reported with `irq`.
- R8: After a stop condition, bytes clocked without a new start are neither acknowledged nor reported.
- R9: A start condition in the middle of a byte restarts bit counting, so the next eight bits are taken as a fresh address byte.
- R10: `irq` is never high for two cycles in a row.
- R11: After reset, `sclLow`, `sdaLow` and `irq` are 0 and `rxData` is 0.
- R12: On an address match, `rwFlag` holds the eighth bit of the address byte (1 = read request, 0 = write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Wired level of SCL |
| sdaIn | input | 1 | Wired level of SDA |
| sclLow | output | 1 | Pull SCL low (clock stretch) |
| sdaLow | output | 1 | Pull SDA low (ACK) |
| ownAddr | input | 7 | Target address to answer |
| ackEnable | input | 1 | Acknowledge data bytes when 1 |
| waitRelease | input | 1 | One-cycle strobe that ends the stretch |
| rxData | output | 8 | Last received data byte |
| rwFlag | output | 1 | Direction bit of the last matched address |
| irq | output | 1 | One-cycle interrupt pulse |
| irqAddr | output | 1 | 1 = pulse is for an address match, 0 = data byte end |

## Verification
The assertions assume that the controller follows the bus rules at the oversampled level. SDA changes only while SCL is low, except for start and stop. Each SCL phase lasts well beyond the synchronizer delay. No start or stop is driven while the target holds SCL low.

The bench's controller model respects these assumptions. It drives SCL and SDA through a wired-AND with the target's pull-downs, and it moves SDA a few cycles after each SCL fall. It does not raise SCL again until software has released the stretch and the wired line reads high.

// File: rtl/i2cTgtPkg.sv
package i2cTgtPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } tgtState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchData;
    logic latchRw;
  } ctlStrb_t;

  // bus events from datapath to control
  typedef struct packed {
    logic startDet;
    logic stopDet;
    logic byteEvt;
    logic addrHit;
    logic ackSlot;
    logic ninthFall;
  } busEvt_t;

endpackage

// File: rtl/i2cTgtDatapath.sv
module i2cTgtDatapath
  import i2cTgtPkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  ctlStrb_t          strb,
  output busEvt_t           evt,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [DATA_W-1:0] rxData,
  output logic              rwFlag
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] NINTH    = CNT_W'(DATA_W + 1);

  logic sclS, sdaS, sclPrev, sdaPrev;

  generate
    if (SYNC_STAGES > 1) begin : gSyncChain
      logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
      end
      assign sclS = sclPipe[SYNC_STAGES-1];
      assign sdaS = sdaPipe[SYNC_STAGES-1];
    end else begin : gSyncSingle
      logic sclQ, sdaQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclQ <= 1'b1;
          sdaQ <= 1'b1;
        end else begin
          sclQ <= sclIn;
          sdaQ <= sdaIn;
        end
      end
      assign sclS = sclQ;
      assign sdaS = sdaQ;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  logic sclRise, sclFall;
  logic [DATA_W-1:0] shiftReg, byteNext;

  assign sclRise      = sclS & ~sclPrev;
  assign sclFall      = ~sclS & sclPrev;
  assign byteNext     = {shiftReg[DATA_W-2:0], sdaS};
  assign evt.startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign evt.stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign evt.byteEvt  = sclRise && (bitCnt == LAST_BIT);
  assign evt.addrHit  = (byteNext[DATA_W-1:DATA_W-ADDR_W] == ownAddr);
  assign evt.ackSlot  = sclFall && (bitCnt == ACK_BIT);
  assign evt.ninthFall = sclFall && (bitCnt == NINTH);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (evt.startDet || evt.stopDet) begin
      bitCnt <= '0;
    end else if (sclRise && (bitCnt < NINTH)) begin
      bitCnt <= bitCnt + 1'b1;
      if (bitCnt < ACK_BIT) shiftReg <= byteNext;
    end else if (evt.ninthFall) begin
      bitCnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
      rwFlag <= 1'b0;
    end else begin
      if (strb.latchData) rxData <= byteNext;
      if (strb.latchRw)   rwFlag <= byteNext[0];
    end
  end

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= NINTH);
  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    evt.startDet |=> (bitCnt == '0));

endmodule

// File: rtl/i2cTgtControl.sv
module i2cTgtControl
  import i2cTgtPkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  busEvt_t          evt,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic             ackEnable,
  input  logic             waitRelease,
  output ctlStrb_t         strb,
  output logic             sclLow,
  output logic             sdaLow,
  output logic             irq,
  output logic             irqAddr
);

  tgtState_t state;
  logic pendAck;

  assign strb.latchData = evt.byteEvt && (state == ST_DATA);
  assign strb.latchRw   = evt.byteEvt && (state == ST_ADDR) && evt.addrHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pendAck <= 1'b0;
      sclLow  <= 1'b0;
      sdaLow  <= 1'b0;
      irq     <= 1'b0;
      irqAddr <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (evt.startDet || evt.stopDet) begin
        state   <= evt.startDet ? ST_ADDR : ST_IDLE;
        pendAck <= 1'b0;
        sclLow  <= 1'b0;
        sdaLow  <= 1'b0;
      end else begin
        if (waitRelease) sclLow <= 1'b0;
        if (evt.byteEvt) begin
          if (state == ST_ADDR) begin
            if (evt.addrHit) pendAck <= 1'b1;
            else             state   <= ST_SKIP;
          end else if (state == ST_DATA) begin
            pendAck <= ackEnable;
          end
        end
        if (evt.ackSlot) sdaLow <= pendAck;
        if (evt.ninthFall) begin
          sdaLow  <= 1'b0;
          pendAck <= 1'b0;
          if (state == ST_ADDR || state == ST_DATA) begin
            sclLow  <= 1'b1;
            irq     <= 1'b1;
            irqAddr <= (state == ST_ADDR);
            state   <= ST_DATA;
          end
        end
      end
    end
  end

  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  p_irq_stalls_r2: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> sclLow);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sclLow && !waitRelease && !evt.startDet && !evt.stopDet) |=> sclLow);
  p_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sclLow && waitRelease && !evt.ninthFall && !evt.startDet) |=> !sclLow);
  p_ack_window_r1: assert property (@(posedge clk) disable iff (!rstN)
    sdaLow |-> (bitCnt == CNT_W'(DATA_W) || bitCnt == CNT_W'(DATA_W + 1)));
  p_skip_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> (!irq && !sdaLow));

endmodule

// File: rtl/i2cTgtStretch.sv
module i2cTgtStretch
  import i2cTgtPkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclLow,
  output logic              sdaLow,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              ackEnable,
  input  logic              waitRelease,
  output logic [DATA_W-1:0] rxData,
  output logic              rwFlag,
  output logic              irq,
  output logic              irqAddr
);

  localparam int CNT_W = $clog2(DATA_W + 2);

  ctlStrb_t         strb;
  busEvt_t          evt;
  logic [CNT_W-1:0] bitCnt;

  i2cTgtDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ownAddr(ownAddr), .strb(strb), .evt(evt), .bitCnt(bitCnt),
    .rxData(rxData), .rwFlag(rwFlag)
  );

  i2cTgtControl #(.DATA_W(DATA_W)) control_i (
    .clk(clk), .rstN(rstN), .evt(evt), .bitCnt(bitCnt),
    .ackEnable(ackEnable), .waitRelease(waitRelease), .strb(strb),
    .sclLow(sclLow), .sdaLow(sdaLow), .irq(irq), .irqAddr(irqAddr)
  );

endmodule

// File: tb/i2cTgtStretch_tb.sv
module i2cTgtStretch_tb_top;

  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sclLow, sdaLow, rwFlag, irq, irqAddr;
  logic [6:0] ownAddr = 7'h5A;
  logic ackEnable = 1'b1;
  logic waitRelease = 1'b0;
  logic [7:0] rxData;
  logic sclBus, sdaBus;

  int vectors = 0;
  int fails = 0;
  logic [9:0] expQ[$];   // {isAddr, rw, data}
  logic prevIrq = 1'b0;

  always #4 clk = ~clk;

  assign sclBus = sclDrv & ~sclLow;
  assign sdaBus = sdaDrv & ~sdaLow;

  i2cTgtStretch dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclBus), .sdaIn(sdaBus),
    .sclLow(sclLow), .sdaLow(sdaLow), .ownAddr(ownAddr),
    .ackEnable(ackEnable), .waitRelease(waitRelease),
    .rxData(rxData), .rwFlag(rwFlag), .irq(irq), .irqAddr(irqAddr)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each interrupt
  always @(negedge clk) begin
    if (rstN) begin
      if (irq) begin
        check(!prevIrq, "R10 irq width", {31'd0, prevIrq}, 32'd0);
        if (expQ.size() == 0) begin
          check(1'b0, "R3/R8 unexpected irq", {31'd0, irqAddr}, 32'd0);
        end else begin
          logic [9:0] e;
          e = expQ.pop_front();
          if (e[9]) begin
            check(irqAddr == 1'b1, "R2 irq kind", {31'd0, irqAddr}, 32'd1);
            check(rwFlag == e[8], "R12 rwFlag", {31'd0, rwFlag}, {31'd0, e[8]});
          end else begin
            check(irqAddr == 1'b0, "R6 irq kind", {31'd0, irqAddr}, 32'd0);
            check(rxData == e[7:0], "R6 rxData", {24'd0, rxData}, {24'd0, e[7:0]});
          end
        end
      end
      prevIrq <= irq;
    end
  end

  task automatic halfWait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; sclDrv = 1'b1; halfWait();
    sdaDrv = 1'b0; halfWait();
    sclDrv = 1'b0; halfWait();
  endtask

  task automatic busRestart();
    sdaDrv = 1'b1; halfWait();
    sclDrv = 1'b1; halfWait();
    sdaDrv = 1'b0; halfWait();
    sclDrv = 1'b0; halfWait();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; halfWait();
    sclDrv = 1'b1; halfWait();
    sdaDrv = 1'b1; halfWait();
  endtask

  task automatic clockBits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      sdaDrv = v[7-i]; halfWait();
      sclDrv = 1'b1; halfWait();
      sclDrv = 1'b0; repeat (3) @(negedge clk);
    end
  endtask

  // driver: one byte plus ninth clock, then the software side of the wait
  task automatic xferByte(input logic [7:0] v, input bit expAck,
                          input bit expWait, input string req);
    clockBits(v, 8);
    sdaDrv = 1'b1; halfWait();
    sclDrv = 1'b1; repeat (HALF/2) @(negedge clk);
    check((!sdaBus) == expAck, {req, " ack"}, {31'd0, !sdaBus}, {31'd0, expAck});
    repeat (HALF/2) @(negedge clk);
    sclDrv = 1'b0; repeat (8) @(negedge clk);
    check(sclLow == expWait, {req, " stretch"}, {31'd0, sclLow}, {31'd0, expWait});
    if (expWait) begin
      repeat (30) @(negedge clk);
      check(sclLow == 1'b1, "R4 hold", {31'd0, sclLow}, 32'd1);
      waitRelease = 1'b1; @(negedge clk);
      waitRelease = 1'b0;
      check(sclLow == 1'b0, "R4 release", {31'd0, sclLow}, 32'd0);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(sclLow == 0, "R11 sclLow", {31'd0, sclLow}, 0);
    check(sdaLow == 0, "R11 sdaLow", {31'd0, sdaLow}, 0);
    check(irq == 0, "R11 irq", {31'd0, irq}, 0);
    check(rxData == 0, "R11 rxData", {24'd0, rxData}, 0);
    halfWait();

    // matched write: address, two acked bytes, one with ackEnable=0
    busStart();
    expQ.push_back({1'b1, 1'b0, 8'h00});
    xferByte({7'h5A, 1'b0}, 1, 1, "R1 R2");
    expQ.push_back({2'b00, 8'hA5});
    xferByte(8'hA5, 1, 1, "R5 R6");
    ackEnable = 1'b0;
    expQ.push_back({2'b00, 8'h3C});
    xferByte(8'h3C, 0, 1, "R7");
    ackEnable = 1'b1;
    busStop();
    check(expQ.size() == 0, "R2 R6 all reported", expQ.size(), 0);

    // mismatched address: silent, data ignored
    busStart();
    xferByte({7'h12, 1'b0}, 0, 0, "R3");
    xferByte(8'hFF, 0, 0, "R3");
    busStop();
    check(rxData == 8'h3C, "R3 rxData kept", {24'd0, rxData}, 32'h3C);

    // bytes after stop without a start
    sclDrv = 1'b0; halfWait();
    xferByte({7'h5A, 1'b0}, 0, 0, "R8");
    xferByte(8'h81, 0, 0, "R8");
    busStop();
    check(rxData == 8'h3C, "R8 rxData kept", {24'd0, rxData}, 32'h3C);

    // read-direction address, aborted byte, repeated start
    busStart();
    expQ.push_back({1'b1, 1'b1, 8'h00});
    xferByte({7'h5A, 1'b1}, 1, 1, "R12");
    clockBits(8'hF0, 4);
    busRestart();
    expQ.push_back({1'b1, 1'b0, 8'h00});
    xferByte({7'h5A, 1'b0}, 1, 1, "R9");
    expQ.push_back({2'b00, 8'h69});
    xferByte(8'h69, 1, 1, "R9 R6");
    busStop();
    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R9 all reported", expQ.size(), 0);
    check(sdaLow == 0 && sclLow == 0, "R4 idle bus", {30'd0, sdaLow, sclLow}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule